// File: doc/BRIEF.md
# Bridge Interrupt Status Register

This block collects interrupt-worthy conditions of a bus bridge into one status word. The word is read and cleared through a simple memory-mapped register port. Three error sources arrive as single-cycle pulses: a failed outbound write, a failed outbound read, and non-prefetchable read data that was dropped because the requester never came back for it. Two level signals are watched for transitions. These are the master-enable control bit and an active-low interrupt line. Each latched condition stays set until software writes a 1 to its position. The three error bits can also be cleared through a clear strobe that comes from the aliased status view on the far side of the bridge. A single interrupt output is high while any status bit is set.

Each level input passes through a small edge tracker. The tracker has a sample flop, followed by a two-state machine with states `LVL_LO` and `LVL_HI` that records the previous sample. In `LVL_LO`, a high sample produces a rise pulse and is the transition to `LVL_HI`. In `LVL_HI`, a low sample produces a fall pulse and is the transition back to `LVL_LO`. If the sample matches the state, the machine stays where it is and no pulse is produced. The state and the sample both reset to the input's idle level, so leaving reset never creates an edge.

The parameters `MODE` (plain, peripheral or host bridge) and `HAS_NP_PORT` decide which bits exist.

Top module: `brg_irq_status`

## Requirements
- R1: A read at byte address 0x3060 returns the status in bits 6:0, and bit 5 and bits 31:7 are always 0. A read at any other address returns 0.
- R2: A one-cycle pulse on `ev_wr_fail` sets bit 0, and a one-cycle pulse on `ev_rd_fail` sets bit 1. Either bit reads as 1 from the cycle after the pulse.
- R3: A one-cycle pulse on `ev_np_drop` sets bit 2 from the cycle after the pulse.
- R4: A 1-to-0 change of `mst_en` sets bit 3, and a 0-to-1 change sets bit 4. The bit reads as 1 two clock edges after the input changes.
- R5: A 1-to-0 change of `irq_line_n` sets bit 6 two clock edges later. A 0-to-1 change sets nothing.
- R6: A register write to 0x3060 clears every bit whose data bit is 1 and leaves the other bits unchanged. A write to any other address clears nothing.
- R7: An `alias_clr_en` strobe clears bits 0 to 2 where `alias_clr_data` is 1. It never touches bits 3, 4 or 6.
- R8: If a set event for a bit occurs in the same cycle as a clear of that bit, the bit ends at 1.
- R9: Bits 0, 1, 3 and 4 exist only in peripheral or host-bridge mode. Bit 2 exists only when `HAS_NP_PORT` is 1. Bit 6 exists only in host-bridge mode. An absent bit always reads 0.
- R10: `irq_o` is 1 exactly when some status bit is 1. It goes low in the cycle after the last set bit is cleared.
- R11: After reset, the status is 0 and `irq_o` is 0. With `mst_en` at 0 and `irq_line_n` at 1, no bit sets after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Write data (a 1 clears that bit) |
| reg_rdata | output | DATA_W | Read data, combinational from `reg_addr` |
| alias_clr_en | input | 1 | Clear strobe from the aliased far-side view |
| alias_clr_data | input | 3 | Clear mask for bits 2:0 |
| ev_wr_fail | input | 1 | Pulse: outbound write failed |
| ev_rd_fail | input | 1 | Pulse: outbound read failed |
| ev_np_drop | input | 1 | Pulse: non-prefetchable read data dropped |
| mst_en | input | 1 | Master-enable control level |
| irq_line_n | input | 1 | Active-low interrupt line level |
| irq_o | output | 1 | High while any status bit is set |

## Verification
The hardest situation to create is a clear landing in the same cycle as a new set for the same bit. For the level-driven bits, the edge pulse exists for only one cycle, two edges after the input moves.

The bench moves the level at a falling edge and lets one clock pass. It then issues the register write exactly in the cycle where the edge pulse is live.

For the pulse bits, it sweeps every combination of three event pulses against every three-bit clear pattern. A reduced second instance, built without bits 2 and 6, sees the same stimulus so that absent bits are checked at every step.

// File: rtl/brg_irq_pkg.sv
package brg_irq_pkg;

    typedef enum logic [1:0] {
        BRG_PLAIN  = 2'd0,
        BRG_PERIPH = 2'd1,
        BRG_HOST   = 2'd2
    } brg_mode_e;

    localparam int STAT_W  = 7;
    localparam int ALIAS_W = 3;

    localparam int B_WR_FAIL  = 0;
    localparam int B_RD_FAIL  = 1;
    localparam int B_NP_DROP  = 2;
    localparam int B_MEN_FALL = 3;
    localparam int B_MEN_RISE = 4;
    localparam int B_IRQ_FALL = 6;

    function automatic logic [STAT_W-1:0] impl_mask(brg_mode_e mode, bit has_np);
        logic ext;
        logic [STAT_W-1:0] m;
        ext           = (mode == BRG_PERIPH) || (mode == BRG_HOST);
        m             = '0;
        m[B_WR_FAIL]  = ext;
        m[B_RD_FAIL]  = ext;
        m[B_NP_DROP]  = has_np;
        m[B_MEN_FALL] = ext;
        m[B_MEN_RISE] = ext;
        m[B_IRQ_FALL] = (mode == BRG_HOST);
        return m;
    endfunction

endpackage

// File: rtl/brg_level_edge.sv
module brg_level_edge #(
    parameter bit IDLE_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_state_e;

    logic       smp_q;
    lvl_state_e state_q;

    // State register: sample the level, then remember the previous sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q   <= IDLE_LVL;
            state_q <= lvl_state_e'(IDLE_LVL);
        end else begin
            smp_q   <= level_i;
            state_q <= smp_q ? LVL_HI : LVL_LO;
        end
    end

    // Outputs: a pulse on the transition out of the current state.
    always_comb begin
        rise_o = 1'b0;
        fall_o = 1'b0;
        unique case (state_q)
            LVL_LO: rise_o = smp_q;
            LVL_HI: fall_o = !smp_q;
        endcase
    end

    // R4/R5: an input rise or fall is reported one edge after it is sampled.
    p_edge_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_i) |=> rise_o);
    p_edge_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level_i) |=> fall_o);

endmodule

// File: rtl/brg_stat_bit.sv
module brg_stat_bit #(
    parameter bit IMPL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // A set event always wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= IMPL && (set_i || (q_o && !clr_i));
    end

    if (IMPL) begin : g_impl
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> q_o);
        p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i) |=> !q_o);
        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i && !clr_i) |=> $stable(q_o));
    end else begin : g_absent
        p_absent_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> !q_o);
    end

endmodule

// File: rtl/brg_irq_status.sv
module brg_irq_status
    import brg_irq_pkg::*;
#(
    parameter int               ADDR_W      = 14,
    parameter int               DATA_W      = 32,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 14'h3060,
    parameter brg_mode_e        MODE        = BRG_HOST,
    parameter bit               HAS_NP_PORT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr_en,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               alias_clr_en,
    input  logic [ALIAS_W-1:0] alias_clr_data,
    input  logic               ev_wr_fail,
    input  logic               ev_rd_fail,
    input  logic               ev_np_drop,
    input  logic               mst_en,
    input  logic               irq_line_n,
    output logic               irq_o
);

    localparam logic [STAT_W-1:0] MASK = impl_mask(MODE, HAS_NP_PORT);

    logic              men_rise, men_fall;
    logic              irqn_rise, irqn_fall;
    logic              wr_hit, rd_hit;
    logic [STAT_W-1:0] set_vec, clr_vec, stat;
    logic              unused_inputs;

    assign unused_inputs = ^{reg_wdata[DATA_W-1:STAT_W], irqn_rise};

    brg_level_edge #(.IDLE_LVL(1'b0)) u_men_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (mst_en),
        .rise_o  (men_rise),
        .fall_o  (men_fall)
    );

    brg_level_edge #(.IDLE_LVL(1'b1)) u_irqn_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (irq_line_n),
        .rise_o  (irqn_rise),
        .fall_o  (irqn_fall)
    );

    assign wr_hit = reg_wr_en && (reg_addr == REG_OFFSET);
    assign rd_hit = (reg_addr == REG_OFFSET);

    always_comb begin
        set_vec             = '0;
        set_vec[B_WR_FAIL]  = ev_wr_fail;
        set_vec[B_RD_FAIL]  = ev_rd_fail;
        set_vec[B_NP_DROP]  = ev_np_drop;
        set_vec[B_MEN_FALL] = men_fall;
        set_vec[B_MEN_RISE] = men_rise;
        set_vec[B_IRQ_FALL] = irqn_fall;
    end

    always_comb begin
        clr_vec = wr_hit ? reg_wdata[STAT_W-1:0] : '0;
        if (alias_clr_en) clr_vec[ALIAS_W-1:0] = clr_vec[ALIAS_W-1:0] | alias_clr_data;
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        brg_stat_bit #(.IMPL(MASK[i])) u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[i]),
            .clr_i (clr_vec[i]),
            .q_o   (stat[i])
        );
    end

    assign reg_rdata = rd_hit ? {{(DATA_W-STAT_W){1'b0}}, stat} : '0;
    assign irq_o     = |stat;

    // R4: the tracker outputs reach the status word on the next edge.
    p_men_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (men_fall && MASK[B_MEN_FALL]) |=> stat[B_MEN_FALL]);
    p_men_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (men_rise && MASK[B_MEN_RISE]) |=> stat[B_MEN_RISE]);
    // R5: an irq line fall is latched.
    p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irqn_fall && MASK[B_IRQ_FALL]) |=> stat[B_IRQ_FALL]);
    // R7: the alias strobe alone never clears the level-driven bits.
    p_alias_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alias_clr_en && !wr_hit && stat[B_MEN_RISE]) |=> stat[B_MEN_RISE]);
    // R10: with no set and every set bit cleared, the interrupt drops.
    p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec == '0) && ((stat & ~clr_vec) == '0)) |=> !irq_o);

endmodule

// File: tb/test_brg_irq_status.sv
module test_brg_irq_status;
    import brg_irq_pkg::*;

    localparam int          CLK_PERIOD = 10;
    localparam int          WATCHDOG   = 20000;
    localparam logic [13:0] OFF        = 14'h3060;
    localparam logic [6:0]  MASK_A     = 7'h5F;
    localparam logic [6:0]  MASK_B     = 7'h1B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] reg_addr = OFF;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        alias_clr_en = 1'b0;
    logic [2:0]  alias_clr_data = '0;
    logic        ev_wr_fail = 1'b0, ev_rd_fail = 1'b0, ev_np_drop = 1'b0;
    logic        mst_en = 1'b0, irq_line_n = 1'b1;
    logic [31:0] rd_a, rd_b;
    logic        irq_a, irq_b;
    logic [6:0]  exp_a = '0, exp_b = '0;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brg_irq_status i_brg_irq_status (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(rd_a), .alias_clr_en(alias_clr_en),
        .alias_clr_data(alias_clr_data), .ev_wr_fail(ev_wr_fail),
        .ev_rd_fail(ev_rd_fail), .ev_np_drop(ev_np_drop), .mst_en(mst_en),
        .irq_line_n(irq_line_n), .irq_o(irq_a)
    );

    brg_irq_status #(.MODE(BRG_PERIPH), .HAS_NP_PORT(1'b0)) i_brg_irq_status_min (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(rd_b), .alias_clr_en(alias_clr_en),
        .alias_clr_data(alias_clr_data), .ev_wr_fail(ev_wr_fail),
        .ev_rd_fail(ev_rd_fail), .ev_np_drop(ev_np_drop), .mst_en(mst_en),
        .irq_line_n(irq_line_n), .irq_o(irq_b)
    );

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    // One clock: the expected word follows the clear/set rules of R6, R7 and R8.
    task automatic step(input logic [6:0] setv);
        logic [6:0] c;
        c = ((reg_wr_en && reg_addr == OFF) ? reg_wdata[6:0] : 7'h0) |
            (alias_clr_en ? {4'h0, alias_clr_data} : 7'h0);
        @(posedge clk);
        exp_a = ((exp_a & ~c) | setv) & MASK_A;
        exp_b = ((exp_b & ~c) | setv) & MASK_B;
        @(negedge clk);
        reg_wr_en = 1'b0; alias_clr_en = 1'b0; reg_addr = OFF;
        ev_wr_fail = 1'b0; ev_rd_fail = 1'b0; ev_np_drop = 1'b0;
    endtask

    task automatic check(input string req);
        #1;
        cmp({req, " host"}, rd_a, {25'h0, exp_a});
        cmp({req, " R9 reduced"}, rd_b, {25'h0, exp_b});
        cmp({req, " R10 irq host"}, {31'h0, irq_a}, {31'h0, |exp_a});
        cmp({req, " R10 irq reduced"}, {31'h0, irq_b}, {31'h0, |exp_b});
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = OFF; reg_wdata = d;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 in reset");
        rst_n = 1'b1;
        step(7'h0); step(7'h0); step(7'h0);
        check("R11 no false edge");

        // R2/R3: each pulse source
        for (int b = 0; b < 3; b++) begin
            case (b)
                0: ev_wr_fail = 1'b1;
                1: ev_rd_fail = 1'b1;
                default: ev_np_drop = 1'b1;
            endcase
            step(7'(1 << b));
            check(b == 2 ? "R3 np drop" : "R2 fail pulse");
        end
        // R6: write 0, write elsewhere, read elsewhere
        wr(32'h0); step(7'h0); check("R6 write zero");
        wr(32'hFFFF_FFFF); reg_addr = OFF + 14'd4; step(7'h0); check("R6 other address");
        reg_addr = OFF + 14'd4; #1;
        cmp("R1 other address read", rd_a, 32'h0);
        reg_addr = OFF;
        for (int b = 0; b < 3; b++) begin
            wr(32'(1 << b)); step(7'h0); check("R6 single clear");
        end

        // R4: master enable rise then fall
        mst_en = 1'b1; step(7'h0); check("R4 rise not yet");
        step(7'h10); check("R4 rise");
        // R7: alias clears only bits 2:0
        ev_wr_fail = 1'b1; ev_np_drop = 1'b1; step(7'h05);
        alias_clr_en = 1'b1; alias_clr_data = 3'b111; step(7'h0); check("R7 alias clear");
        mst_en = 1'b0; step(7'h0); step(7'h08); check("R4 fall");
        // R5: irq line fall sets, rise does not
        irq_line_n = 1'b0; step(7'h0); step(7'h40); check("R5 fall");
        irq_line_n = 1'b1; step(7'h0); step(7'h0); check("R5 rise ignored");
        // R1: full readback, reserved bits zero
        ev_wr_fail = 1'b1; ev_rd_fail = 1'b1; ev_np_drop = 1'b1; step(7'h07);
        check("R1 readback");

        // R8: level edge pulse meets a clear
        wr(32'h10); step(7'h0); check("R6 clear rise");
        mst_en = 1'b1; step(7'h0);
        wr(32'h10); step(7'h10); check("R8 rise vs clear");
        irq_line_n = 1'b0; step(7'h0);
        wr(32'h40); step(7'h40); check("R8 irq fall vs clear");
        irq_line_n = 1'b1; step(7'h0);

        // R8 sweep: every pulse set against every clear pattern, both views
        for (int p = 0; p < 8; p++) begin
            for (int w = 0; w < 8; w++) begin
                ev_wr_fail = p[0]; ev_rd_fail = p[1]; ev_np_drop = p[2];
                if (w[0] ^ p[0]) begin
                    alias_clr_en = 1'b1; alias_clr_data = 3'(w);
                end else begin
                    wr(32'(w));
                end
                step(7'(p)); check("R8 sweep");
            end
        end

        // R10: clearing everything drops the interrupt
        wr(32'hFFFF_FFFF); step(7'h0); check("R10 all cleared");
        cmp("R10 irq low", {31'h0, irq_a}, 32'h0);

        summary();
        $finish;
    end

endmodule